// File: doc/BRIEF.md
# Receive FIFO Character-Timeout Detector

This block sits beside a UART receive FIFO and flags data that has been left waiting. While the FIFO holds at least one character, a timer counts receiver-clock ticks (sixteen per bit time). The timer runs only while neither a push nor a pop occurs. When the count reaches a window, the timeout flag is raised. Software uses this flag to drain a message tail that is shorter than the programmed trigger level. Such a tail would otherwise never reach the trigger point.

The window is not fixed. It has a base part that grows with the word length. It also has an occupancy part that grows with the distance between the trigger level and the number of characters currently stored. Any FIFO push or pop clears the flag and restarts the count. An empty FIFO holds the timer and the flag at zero.

Top module: `rx_char_timeout`

## Requirements
- R1: After a synchronous reset the flag `to_o` is low, and it stays low until a full window of ticks has elapsed with data stored.
- R2: `wlen_i` encodes the data bits as 0=5, 1=6, 2=7 and 3=8 bits. The window in ticks is ((bits*7)-2)*8 + (occ*8 + 1). For example, with the occupancy term at zero the window is 265 ticks for 5 bits and 433 ticks for 8 bits.
- R3: The value occ equals trigger level minus `fifo_cnt_i` when the count is below the trigger level, and equals zero when the count is at or above it. The trigger level is first limited to MAX_TRIG.
- R4: Only clock cycles with `tick_i` high advance the timer. `to_o` goes high on the clock edge of the tick that completes the window.
- R5: A cycle with `push_i` or `pop_i` high clears `to_o` at the next edge and restarts the count from zero.
- R6: While `fifo_cnt_i` is zero, the timer is held at zero and `to_o` is low, including directly after a pop that empties the FIFO.
- R7: Once set, `to_o` stays high through further ticks until FIFO activity occurs or the FIFO becomes empty.
- R8: The timer covers the largest window without wrapping. That window is 537 ticks, for 8 bits, a trigger level of 14 and one stored character.
- R9: Take a trigger level of 10 with a 5-character tail left stored and 8-bit words. The flag rises after exactly 473 ticks, so the tail can be collected by a timeout.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_i | input | 1 | Receiver clock enable, 16 per bit |
| wlen_i | input | 2 | Word length code (0..3 = 5..8 bits) |
| trig_i | input | CNT_W | Trigger level in characters |
| fifo_cnt_i | input | CNT_W | Current FIFO occupancy |
| push_i | input | 1 | FIFO write strobe |
| pop_i | input | 1 | FIFO read strobe |
| to_o | output | 1 | Character-timeout flag (registered) |

## Verification
The hardest case to reach is the exact edge of the longest window. This needs 537 uninterrupted ticks with data present and no activity, and random strobes almost never leave that gap. Directed sequences therefore set the longest window and the message-tail window, tick on every cycle, and sample the flag one tick before and at the boundary. Between those sequences, random ticks at half rate are mixed with rare pushes and pops and occasional changes of level and occupancy. This stream is compared on every cycle against a tick-counting model in the bench.

// File: rtl/rxto_pkg.sv
package rxto_pkg;
  typedef enum logic [1:0] {
    WL_5 = 2'd0,
    WL_6 = 2'd1,
    WL_7 = 2'd2,
    WL_8 = 2'd3
  } wlen_e;

  localparam int MIN_BITS     = 5;
  localparam int WL_CODES     = 4;
  localparam int TICKS_STEP   = 8;
  localparam int BITS_FACTOR  = 7;
  localparam int BASE_OFFSET  = 2;

  function automatic int base_ticks(input int bits);
    return (bits * BITS_FACTOR - BASE_OFFSET) * TICKS_STEP;
  endfunction
endpackage

// File: rtl/rxto_window.sv
module rxto_window
  import rxto_pkg::*;
#(
  parameter int CNT_W    = 5,
  parameter int MAX_TRIG = 14,
  parameter int TMR_W    = 10
) (
  input  logic [1:0]       wlen_i,
  input  logic [CNT_W-1:0] trig_i,
  input  logic [CNT_W-1:0] cnt_i,
  output logic [TMR_W-1:0] win_o
);
  logic [TMR_W-1:0] base_lut [WL_CODES];

  for (genvar g = 0; g < WL_CODES; g++) begin : g_base
    assign base_lut[g] = TMR_W'(base_ticks(MIN_BITS + g));
  end

  logic [CNT_W-1:0] trig_eff;
  logic [CNT_W-1:0] occ;

  always_comb begin
    trig_eff = (trig_i > CNT_W'(MAX_TRIG)) ? CNT_W'(MAX_TRIG) : trig_i;
    occ      = (cnt_i >= trig_eff) ? '0 : (trig_eff - cnt_i);
    win_o    = base_lut[wlen_i] + (TMR_W'(occ) * TMR_W'(TICKS_STEP)) + TMR_W'(1);
  end
endmodule

// File: rtl/rxto_timer.sv
module rxto_timer #(
  parameter int TMR_W = 10
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick_i,
  input  logic             hold_i,
  input  logic [TMR_W-1:0] win_i,
  output logic [TMR_W-1:0] tmr_o,
  output logic             flag_o
);
  logic [TMR_W:0] nxt;

  assign nxt = {1'b0, tmr_o} + 1'b1;

  always_ff @(posedge clk) begin
    if (rst || hold_i) begin
      tmr_o  <= '0;
      flag_o <= 1'b0;
    end else if (tick_i && !flag_o) begin
      tmr_o <= nxt[TMR_W-1:0];
      if (nxt >= {1'b0, win_i}) flag_o <= 1'b1;
    end
  end
endmodule

// File: rtl/rx_char_timeout.sv
module rx_char_timeout
  import rxto_pkg::*;
#(
  parameter int DEPTH    = 16,
  parameter int MAX_TRIG = 14,
  localparam int CNT_W   = $clog2(DEPTH + 1),
  localparam int MAX_WIN = base_ticks(MIN_BITS + WL_CODES - 1)
                           + (MAX_TRIG - 1) * TICKS_STEP + 1,
  localparam int TMR_W   = $clog2(MAX_WIN + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick_i,
  input  logic [1:0]       wlen_i,
  input  logic [CNT_W-1:0] trig_i,
  input  logic [CNT_W-1:0] fifo_cnt_i,
  input  logic             push_i,
  input  logic             pop_i,
  output logic             to_o
);
  logic [TMR_W-1:0] win_w;
  logic [TMR_W-1:0] tmr_q;
  logic             hold_w;

  assign hold_w = (fifo_cnt_i == '0) || push_i || pop_i;

  rxto_window #(.CNT_W(CNT_W), .MAX_TRIG(MAX_TRIG), .TMR_W(TMR_W)) u_win (
    .wlen_i (wlen_i),
    .trig_i (trig_i),
    .cnt_i  (fifo_cnt_i),
    .win_o  (win_w)
  );

  rxto_timer #(.TMR_W(TMR_W)) u_tmr (
    .clk    (clk),
    .rst    (rst),
    .tick_i (tick_i),
    .hold_i (hold_w),
    .win_i  (win_w),
    .tmr_o  (tmr_q),
    .flag_o (to_o)
  );
endmodule

// File: rtl/rxto_checker.sv
module rxto_checker #(
  parameter int CNT_W   = 5,
  parameter int TMR_W   = 10,
  parameter int MAX_WIN = 537
) (
  input logic             clk,
  input logic             rst,
  input logic             tick_i,
  input logic             push_i,
  input logic             pop_i,
  input logic [CNT_W-1:0] fifo_cnt_i,
  input logic [TMR_W-1:0] tmr,
  input logic             to_o
);
  // R6: empty FIFO forces the flag low
  a_r6_empty_clears: assert property (@(posedge clk) disable iff (rst)
    (fifo_cnt_i == '0) |=> !to_o);

  // R5: activity clears the flag
  a_r5_activity_clears: assert property (@(posedge clk) disable iff (rst)
    (push_i || pop_i) |=> !to_o);

  // R7: the flag holds while idle with data stored
  a_r7_sticky: assert property (@(posedge clk) disable iff (rst)
    (to_o && !push_i && !pop_i && fifo_cnt_i != '0) |=> to_o);

  // R4: the flag only rises after a tick
  a_r4_rise_on_tick: assert property (@(posedge clk) disable iff (rst)
    $rose(to_o) |-> $past(tick_i));

  // R8: the timer never exceeds the largest window
  a_r8_no_overflow: assert property (@(posedge clk) disable iff (rst)
    tmr <= TMR_W'(MAX_WIN));
endmodule

bind rx_char_timeout rxto_checker #(.CNT_W(CNT_W), .TMR_W(TMR_W), .MAX_WIN(MAX_WIN)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .tick_i     (tick_i),
  .push_i     (push_i),
  .pop_i      (pop_i),
  .fifo_cnt_i (fifo_cnt_i),
  .tmr        (tmr_q),
  .to_o       (to_o)
);

// File: tb/test_rx_char_timeout.sv
module test_rx_char_timeout;
  localparam int CLK_P  = 10;
  localparam int DEPTH  = 16;
  localparam int CNT_W  = $clog2(DEPTH + 1);
  localparam int MAXTRG = 14;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             tick = 1'b0;
  logic [1:0]       wlen = 2'd3;
  logic [CNT_W-1:0] trig = CNT_W'(8);
  logic [CNT_W-1:0] cnt = '0;
  logic             push = 1'b0;
  logic             pop = 1'b0;
  logic             to_o;

  int n_chk = 0;
  int n_bad = 0;
  int m_ticks = 0;
  bit m_flag = 1'b0;
  bit done = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  rx_char_timeout #(.DEPTH(DEPTH), .MAX_TRIG(MAXTRG)) i_rx_char_timeout (
    .clk(clk), .rst(rst), .tick_i(tick), .wlen_i(wlen), .trig_i(trig),
    .fifo_cnt_i(cnt), .push_i(push), .pop_i(pop), .to_o(to_o)
  );

  function automatic int exp_win(input int wl, input int tg, input int c);
    int bits = 5 + wl;
    int t = (tg > MAXTRG) ? MAXTRG : tg;
    int occ = (c >= t) ? 0 : t - c;
    return ((bits * 7) - 2) * 8 + occ * 8 + 1;
  endfunction

  task automatic check(input bit act, input bit exp, input string tag);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: to_o=%0b expected %0b at %0t", tag, act, exp, $time);
    end
  endtask

  // reference: ticks since last activity with data stored
  always @(posedge clk) begin
    if (rst || cnt == 0 || push || pop) begin
      m_ticks = 0;
      m_flag  = 1'b0;
    end else if (tick && !m_flag) begin
      m_ticks++;
      if (m_ticks >= exp_win(wlen, trig, cnt)) m_flag = 1'b1;
    end
  end

  always @(negedge clk) if (!rst && !done) check(to_o, m_flag, "R4 model");

  task automatic window_edge(input int wl, input int tg, input int c, input int win,
                             input string tag);
    @(negedge clk);
    wlen = 2'(wl); trig = CNT_W'(tg); cnt = CNT_W'(c); push = 1'b1; tick = 1'b0;
    @(negedge clk);
    push = 1'b0; tick = 1'b1;
    repeat (win - 1) @(negedge clk);
    check(to_o, 1'b0, {tag, " before edge"});
    @(negedge clk);
    check(to_o, 1'b1, {tag, " at edge"});
  endtask

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    check(to_o, 1'b0, "R1 reset");
    rst = 1'b0;
    @(negedge clk);
    check(to_o, 1'b0, "R1 after reset");

    // R8: longest window
    window_edge(3, 14, 1, exp_win(3, 14, 1), "R8 max window");
    if (exp_win(3, 14, 1) != 537) begin n_bad++; $display("FAIL R8 window calc"); end
    // R7: stays high while idle
    repeat (20) @(negedge clk);
    check(to_o, 1'b1, "R7 sticky");
    // R5: pop clears
    pop = 1'b1; @(negedge clk); pop = 1'b0;
    check(to_o, 1'b0, "R5 pop clears");
    // R9: message tail, trigger 10, five characters left
    window_edge(3, 10, 5, 473, "R9 tail");
    // R3: count at trigger clamps, 5 bits -> 265
    window_edge(0, 4, 9, 265, "R3 clamp");
    // R2: each word length, occupancy term zero
    for (int w = 0; w < 4; w++) window_edge(w, 2, 2, exp_win(w, 2, 2), "R2 wlen");
    // R6: pop emptying the FIFO
    @(negedge clk); cnt = '0; pop = 1'b1;
    @(negedge clk); pop = 1'b0;
    repeat (600) @(negedge clk);
    check(to_o, 1'b0, "R6 empty hold");
    // R5: push restarts mid-window
    window_edge(1, 3, 3, exp_win(1, 3, 3), "R5 restart");
    push = 1'b1; @(negedge clk); push = 1'b0;
    check(to_o, 1'b0, "R5 push clears");

    // constrained random
    for (int i = 0; i < 40000; i++) begin
      tick = ($urandom % 2) == 0;
      push = ($urandom % 500) == 0;
      pop  = !push && (($urandom % 500) == 0);
      if (($urandom % 1500) == 0) begin
        wlen = 2'($urandom % 4);
        trig = CNT_W'(1 + $urandom % MAXTRG);
        cnt  = CNT_W'($urandom % (DEPTH + 1));
      end
      @(negedge clk);
    end
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(CLK_P * 200000);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule